// File: doc/BRIEF.md
# Gated Auto-Reload Timer/Counter

This block is a 16-bit up-counter that reloads itself from a 16-bit reload pair whenever it wraps past all ones, and raises an overflow flag each time it does so. The count advances either once per machine cycle (the core clock divided by 12) or on falling transitions of an external count pin. A gate option lets an external interrupt pin hold the count off while that pin is low. One 8-bit control/status register holds the gate, source and run controls, the overflow flag, and the edge flags and trigger-type bits of two external interrupt inputs.

Software reaches the registers through a small request/response bus. The request side uses valid/ready, but `req_ready` is tied high, so every request is accepted on the cycle it is presented and there is no back-pressure. A read returns its data on the response channel one cycle later. The response channel has no ready, so the master must always accept it. Writes produce no response. The three interrupt requests are plain level outputs, each cleared through its own acknowledge input.

Register addresses are: 0 control, 1 count low byte, 2 count high byte, 3 reload low byte, 4 reload high byte, 5 interrupt enable. The control byte, from bit 7 down to bit 0, is: gate, source (1 = count pin), overflow flag, run, ext0 flag, ext0 edge mode, ext1 flag, ext1 edge mode. In the enable byte, bit 0 is the timer, bit 1 is ext0 and bit 2 is ext1.

Top module: `gated_reload_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0 and all three interrupt outputs are low, with all pins held high.
- R2: `req_ready` is always 1. A read accepted on one clock edge gives `rsp_valid` high with the register value at the next edge. A write gives no response. The register map is the one listed above.
- R3: When run is 1 and gate and source are 0, the count increments exactly once every 12 clock cycles.
- R4: When run is 0, the count holds its value.
- R5: When gate is 1, the count advances only while the synchronised ext0 pin is high. While that pin is low, the count holds.
- R6: When source is 1, the count pin is synchronised and then sampled once per machine cycle. The count increments when one sample is 1 and the next is 0, so there is at most one increment per machine cycle.
- R7: An increment from 0xFFFF loads the count from the reload pair instead. Counting never changes the reload registers.
- R8: An overflow sets the overflow flag (control bit 5). `irq_timer` is that flag ANDed with enable bit 0. Pulsing `ack_timer` clears the flag.
- R9: In edge mode (trigger bit = 1), a falling edge on an ext pin sets its flag (bit 3 for ext0, bit 1 for ext1). The flag stays set after the pin returns high, until its acknowledge input clears it.
- R10: In level mode (trigger bit = 0), an ext flag reads as the inverse of the synchronised pin and is not latched. Its interrupt request follows the flag, ANDed with its enable bit.
- R11: A software write to a count byte on the same edge as an increment wins. The byte takes the written value and the increment is dropped.
- R12: The control byte layout is exactly the bit order given above, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| cnt_pin | input | 1 | External count source pin |
| xint0_pin | input | 1 | External interrupt 0 pin; also the gate pin |
| xint1_pin | input | 1 | External interrupt 1 pin |
| ack_timer | input | 1 | Clears the overflow flag |
| ack_x0 | input | 1 | Clears the latched ext0 edge flag |
| ack_x1 | input | 1 | Clears the latched ext1 edge flag |
| irq_timer | output | 1 | Timer interrupt request |
| irq_x0 | output | 1 | Ext0 interrupt request |
| irq_x1 | output | 1 | Ext1 interrupt request |

## Verification
The assertions check the following on every cycle:
- the spacing of the machine-cycle tick;
- single-step increments and holds of the count;
- the reload value loaded on wrap, and the reload pair staying unchanged;
- write priority on the count bytes;
- the count holding while the gate pin is low;
- the overflow flag being set and cleared;
- edge capture and acknowledge on the external flags;
- the one-cycle read response.

Some properties need the bench's scenarios:
- the exact 12-cycle rate, seen as a count change over a known window;
- the reload contents seen at the ports after a real wrap;
- pin-driven counting in counter mode;
- level-mode flags following the pin;
- a software write landing on a tick edge, which the bench aligns by counting cycles from reset.

// File: rtl/grt_pkg.sv
package grt_pkg;
  // Control/status byte bit positions (MSB to LSB order is behavioural).
  localparam int CB_GATE = 7;
  localparam int CB_SRC  = 6;
  localparam int CB_OVF  = 5;
  localparam int CB_RUN  = 4;
  localparam int CB_X0F  = 3;
  localparam int CB_X0T  = 2;
  localparam int CB_X1F  = 1;
  localparam int CB_X1T  = 0;

  // Interrupt enable bit positions.
  localparam int EN_TMR = 0;
  localparam int EN_X0  = 1;
  localparam int EN_X1  = 2;
  localparam int EN_W   = 3;

  // Number of external interrupt channels.
  localparam int NXINT = 2;
endpackage

// File: rtl/grt_sync.sv
module grt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{RST_VAL}};
    else     sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/grt_prescaler.sv
module grt_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)              div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                  div_q <= div_q + PW'(1);
  end

  assign tick = (div_q == LAST);

  // R3: ticks never come on back-to-back cycles, and the divider restarts after each tick.
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  a_r3_tick_restart: assert property (@(posedge clk) disable iff (rst)
    tick |=> (div_q == '0));
endmodule

// File: rtl/grt_count_core.sv
module grt_count_core #(
  parameter int NBYTE = 2,
  parameter int BW    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inc,
  input  logic [NBYTE-1:0]      wr_cnt,
  input  logic [NBYTE-1:0]      wr_rld,
  input  logic [BW-1:0]         wdata,
  output logic [NBYTE*BW-1:0]   cnt,
  output logic [NBYTE*BW-1:0]   rld,
  output logic                  ovf
);
  localparam int CW = NBYTE * BW;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rld_q;
  logic          any_wr;
  logic          step;

  assign any_wr = |wr_cnt;
  assign step   = inc & ~any_wr;   // software write wins over the increment
  assign ovf    = step & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (any_wr) begin
      for (int k = 0; k < NBYTE; k++)
        if (wr_cnt[k]) cnt_q[k*BW +: BW] <= wdata;
    end else if (step) begin
      cnt_q <= (&cnt_q) ? rld_q : cnt_q + CW'(1);
    end
  end

  generate
    for (genvar k = 0; k < NBYTE; k++) begin : g_rld
      always_ff @(posedge clk) begin
        if (rst)           rld_q[k*BW +: BW] <= '0;
        else if (wr_rld[k]) rld_q[k*BW +: BW] <= wdata;
      end

      // R11: a written byte carries the written value on the next cycle.
      a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_cnt[k] |=> (cnt_q[k*BW +: BW] == $past(wdata)));
    end
  endgenerate

  assign cnt = cnt_q;
  assign rld = rld_q;

  // R4: without an increment or a write the count holds.
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !any_wr) |=> $stable(cnt_q));
  // R3: an increment below all ones adds exactly one.
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !any_wr && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R7: wrap loads the reload value, and counting never alters the reload pair.
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt_q == $past(rld_q)));
  a_r7_rld_keep: assert property (@(posedge clk) disable iff (rst)
    !(|wr_rld) |=> $stable(rld_q));
endmodule

// File: rtl/grt_ext_irq.sv
module grt_ext_irq (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic ack,
  output logic flag
);
  logic prev_q;
  logic latched_q;
  logic fall;

  assign fall = prev_q & ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_s;
  end

  always_ff @(posedge clk) begin
    if (rst)            latched_q <= 1'b0;
    else if (!edge_mode) latched_q <= 1'b0;
    else if (fall)      latched_q <= 1'b1;
    else if (sw_wr)     latched_q <= sw_val;
    else if (ack)       latched_q <= 1'b0;
  end

  assign flag = edge_mode ? latched_q : ~pin_s;

  // R9: a falling edge in edge mode is captured.
  a_r9_edge_capture: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && fall) |=> (latched_q || !edge_mode));
  // R9: an acknowledge with no new edge or write clears the flag.
  a_r9_ack_clear: assert property (@(posedge clk) disable iff (rst)
    (ack && !fall && !sw_wr) |=> !latched_q);
  // R10: level mode keeps nothing latched.
  a_r10_no_latch: assert property (@(posedge clk) disable iff (rst)
    !edge_mode |=> !latched_q);
endmodule

// File: rtl/gated_reload_timer.sv
module gated_reload_timer
  import grt_pkg::*;
#(
  parameter int NBYTE    = 2,
  parameter int BUS_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int PRESCALE = 12,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_data,
  input  logic              cnt_pin,
  input  logic              xint0_pin,
  input  logic              xint1_pin,
  input  logic              ack_timer,
  input  logic              ack_x0,
  input  logic              ack_x1,
  output logic              irq_timer,
  output logic              irq_x0,
  output logic              irq_x1
);
  localparam int CW     = NBYTE * BUS_W;
  localparam int NPIN   = 1 + NXINT;
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(1 + 2 * NBYTE);

  // ---------------- pin synchronisers ----------------
  logic [NPIN-1:0] pin_raw, pin_s;
  assign pin_raw = {xint1_pin, xint0_pin, cnt_pin};

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_sync
      grt_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
        .clk (clk), .rst (rst), .din (pin_raw[i]), .dout (pin_s[i]));
    end
  endgenerate

  logic cnt_s;
  logic [NXINT-1:0] x_s;
  assign cnt_s = pin_s[0];
  assign x_s   = pin_s[NPIN-1:1];

  // ---------------- machine-cycle tick ----------------
  logic mc_tick;
  grt_prescaler #(.DIV(PRESCALE)) u_pre (.clk(clk), .rst(rst), .tick(mc_tick));

  // ---------------- bus decode ----------------
  logic acc, wr, wr_ctrl, wr_ien;
  logic [NBYTE-1:0] wr_cnt, wr_rld;

  assign req_ready = 1'b1;
  assign acc     = req_valid;
  assign wr      = acc & req_write;
  assign wr_ctrl = wr && (req_addr == A_CTRL);
  assign wr_ien  = wr && (req_addr == A_IEN);

  generate
    for (genvar k = 0; k < NBYTE; k++) begin : g_dec
      assign wr_cnt[k] = wr && (req_addr == ADDR_W'(1 + k));
      assign wr_rld[k] = wr && (req_addr == ADDR_W'(1 + NBYTE + k));
    end
  endgenerate

  // ---------------- control register ----------------
  logic gate_q, src_q, tf_q, tr_q;
  logic [NXINT-1:0] xt_q;
  logic [EN_W-1:0]  ien_q;
  logic ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      src_q  <= 1'b0;
      tr_q   <= 1'b0;
      xt_q   <= '0;
    end else if (wr_ctrl) begin
      gate_q  <= req_wdata[CB_GATE];
      src_q   <= req_wdata[CB_SRC];
      tr_q    <= req_wdata[CB_RUN];
      xt_q[0] <= req_wdata[CB_X0T];
      xt_q[1] <= req_wdata[CB_X1T];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            tf_q <= 1'b0;
    else if (ovf)       tf_q <= 1'b1;
    else if (wr_ctrl)   tf_q <= req_wdata[CB_OVF];
    else if (ack_timer) tf_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         ien_q <= '0;
    else if (wr_ien) ien_q <= req_wdata[EN_W-1:0];
  end

  // ---------------- count source and gate ----------------
  logic cnt_smp_q, pin_fall, run, inc;

  always_ff @(posedge clk) begin
    if (rst)          cnt_smp_q <= 1'b1;
    else if (mc_tick) cnt_smp_q <= cnt_s;
  end

  assign pin_fall = cnt_smp_q & ~cnt_s;
  assign run      = tr_q & (~gate_q | x_s[0]);
  assign inc      = run & mc_tick & (~src_q | pin_fall);

  // ---------------- counter core ----------------
  logic [CW-1:0] cnt_val, rld_val;

  grt_count_core #(.NBYTE(NBYTE), .BW(BUS_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .inc    (inc),
    .wr_cnt (wr_cnt),
    .wr_rld (wr_rld),
    .wdata  (req_wdata),
    .cnt    (cnt_val),
    .rld    (rld_val),
    .ovf    (ovf)
  );

  // ---------------- external interrupt channels ----------------
  logic [NXINT-1:0] x_flag, x_ack, x_swv;
  assign x_ack = {ack_x1, ack_x0};
  assign x_swv = {req_wdata[CB_X1F], req_wdata[CB_X0F]};

  generate
    for (genvar j = 0; j < NXINT; j++) begin : g_xint
      grt_ext_irq u_x (
        .clk       (clk),
        .rst       (rst),
        .pin_s     (x_s[j]),
        .edge_mode (xt_q[j]),
        .sw_wr     (wr_ctrl),
        .sw_val    (x_swv[j]),
        .ack       (x_ack[j]),
        .flag      (x_flag[j])
      );
    end
  endgenerate

  // ---------------- read path ----------------
  logic [BUS_W-1:0] ctrl_rd, rd_mux;

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_GATE] = gate_q;
    ctrl_rd[CB_SRC]  = src_q;
    ctrl_rd[CB_OVF]  = tf_q;
    ctrl_rd[CB_RUN]  = tr_q;
    ctrl_rd[CB_X0F]  = x_flag[0];
    ctrl_rd[CB_X0T]  = xt_q[0];
    ctrl_rd[CB_X1F]  = x_flag[1];
    ctrl_rd[CB_X1T]  = xt_q[1];
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == A_CTRL) rd_mux = ctrl_rd;
    if (req_addr == A_IEN)  rd_mux[EN_W-1:0] = ien_q;
    for (int k = 0; k < NBYTE; k++) begin
      if (req_addr == ADDR_W'(1 + k))         rd_mux = cnt_val[k*BUS_W +: BUS_W];
      if (req_addr == ADDR_W'(1 + NBYTE + k)) rd_mux = rld_val[k*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc & ~req_write;
      if (acc & ~req_write) rsp_data <= rd_mux;
    end
  end

  // ---------------- interrupt requests ----------------
  assign irq_timer = tf_q      & ien_q[EN_TMR];
  assign irq_x0    = x_flag[0] & ien_q[EN_X0];
  assign irq_x1    = x_flag[1] & ien_q[EN_X1];

  // R8: overflow sets the flag; an acknowledge with no overflow or write clears it.
  a_r8_tf_on_ovf: assert property (@(posedge clk) disable iff (rst)
    ovf |=> tf_q);
  a_r8_ack_clear: assert property (@(posedge clk) disable iff (rst)
    (ack_timer && !ovf && !wr_ctrl) |=> !tf_q);
  // R2: reads answer one cycle later; writes do not answer.
  a_r2_read_rsp: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);
  a_r2_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rsp_valid);
  // R5: with the gate closed by a low ext0 pin, the count holds.
  a_r5_gate_hold: assert property (@(posedge clk) disable iff (rst)
    (tr_q && gate_q && !x_s[0] && !(|wr_cnt)) |=> $stable(cnt_val));
endmodule

// File: tb/tb_gated_reload_timer.sv
`timescale 1ns/1ps
module tb_gated_reload_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic cnt_pin = 1'b1, xint0_pin = 1'b1, xint1_pin = 1'b1;
  logic ack_timer = 1'b0, ack_x0 = 1'b0, ack_x1 = 1'b0;
  logic irq_timer, irq_x0, irq_x1;

  always #4 clk = ~clk;

  gated_reload_timer dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cnt_pin(cnt_pin), .xint0_pin(xint0_pin), .xint1_pin(xint1_pin),
    .ack_timer(ack_timer), .ack_x0(ack_x0), .ack_x1(ack_x1),
    .irq_timer(irq_timer), .irq_x0(irq_x0), .irq_x1(irq_x1));

  typedef struct {
    bit         chk;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  logic [7:0] last_rsp = '0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as read responses appear.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", rsp_data, 0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        last_rsp = rsp_data;
        if (it.chk) check(rsp_data == it.exp, it.tag, rsp_data, it.exp);
      end
    end
  end

  task automatic bus(input bit w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    it.chk = 1'b1; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus(1'b0, a, 8'h00);
    @(negedge clk);
  endtask

  task automatic rd_get(input logic [2:0] a, output logic [7:0] v);
    sb_item_t it;
    it.chk = 1'b0; it.exp = '0; it.tag = "";
    sb_q.push_back(it);
    bus(1'b0, a, 8'h00);
    @(negedge clk);
    #1 v = last_rsp;
  endtask

  task automatic pulse_ack(input int which);
    @(negedge clk);
    if (which == 0) ack_timer = 1'b1;
    if (which == 1) ack_x0 = 1'b1;
    if (which == 2) ack_x1 = 1'b1;
    @(negedge clk);
    ack_timer = 1'b0; ack_x0 = 1'b0; ack_x1 = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v0, v1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) rd_exp(3'(a), 8'h00, "R1 reset register");
    check(!irq_timer && !irq_x0 && !irq_x1, "R1 irqs low", {irq_timer, irq_x0, irq_x1}, 0);
    check(req_ready == 1'b1, "R2 ready", req_ready, 1);

    // R2: map and readback, writes produce no response
    wr(3'd3, 8'hA5);
    check(rsp_valid == 1'b0, "R2 no write response", rsp_valid, 0);
    rd_exp(3'd3, 8'hA5, "R2 reload low readback");
    wr(3'd5, 8'h07);
    rd_exp(3'd5, 8'h07, "R2 enable readback");

    // R4: stopped count holds
    rd_get(3'd1, v0);
    repeat (57) @(negedge clk);
    rd_get(3'd1, v1);
    check(v1 == v0, "R4 hold while stopped", v1, v0);

    // R3: one increment per 12 clocks (120-cycle window between read accepts)
    wr(3'd0, 8'h10);
    rd_get(3'd1, v0);
    repeat (117) @(negedge clk);
    rd_get(3'd1, v1);
    check(8'(v1 - v0) == 8'd10, "R3 rate", 8'(v1 - v0), 10);

    // R7/R8: overflow reloads and flags
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h34);
    wr(3'd4, 8'h12);
    wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h10);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (irq_timer) break;
    end
    check(irq_timer == 1'b1, "R8 irq on overflow", irq_timer, 1);
    wr(3'd0, 8'h20);
    rd_exp(3'd1, 8'h34, "R7 low byte reloaded");
    rd_exp(3'd2, 8'h12, "R7 high byte reloaded");
    rd_exp(3'd3, 8'h34, "R7 reload low kept");
    rd_exp(3'd4, 8'h12, "R7 reload high kept");
    rd_exp(3'd0, 8'h20, "R12 overflow flag at bit 5");
    pulse_ack(0);
    check(irq_timer == 1'b0, "R8 ack clears irq", irq_timer, 0);
    rd_exp(3'd0, 8'h00, "R8 flag cleared");

    // R11: write lands on a tick edge and wins
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h10);
    do @(negedge clk); while ((cyc % 12) != 11);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd1; req_wdata = 8'h55;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd_exp(3'd1, 8'h55, "R11 write beats increment");

    // R5 + R10: gate closed by low ext0 pin (level mode)
    xint0_pin = 1'b0;
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h90);
    check(irq_x0 == 1'b1, "R10 level irq ext0", irq_x0, 1);
    rd_exp(3'd0, 8'h98, "R10 level flag ext0 / R12 layout");
    rd_get(3'd1, v0);
    repeat (117) @(negedge clk);
    rd_get(3'd1, v1);
    check(v1 == v0, "R5 gate low holds", v1, v0);
    xint0_pin = 1'b1;
    repeat (5) @(negedge clk);
    check(irq_x0 == 1'b0, "R10 level irq released", irq_x0, 1'b0);
    rd_get(3'd1, v0);
    repeat (117) @(negedge clk);
    rd_get(3'd1, v1);
    check(8'(v1 - v0) == 8'd10, "R5 gate high counts", 8'(v1 - v0), 10);

    // R6: counter mode on pin falls
    wr(3'd0, 8'h50);
    repeat (30) @(negedge clk);
    rd_get(3'd1, v0);
    for (int p = 0; p < 5; p++) begin
      cnt_pin = 1'b0;
      repeat (24) @(negedge clk);
      cnt_pin = 1'b1;
      repeat (24) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    rd_get(3'd1, v1);
    check(8'(v1 - v0) == 8'd5, "R6 counts pin falls", 8'(v1 - v0), 5);
    rd_get(3'd1, v0);
    for (int t = 0; t < 180; t++) begin
      cnt_pin = ((t % 18) < 9) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    cnt_pin = 1'b1;
    repeat (30) @(negedge clk);
    rd_get(3'd1, v1);
    check(8'(v1 - v0) <= 8'd18, "R6 at most one per machine cycle", 8'(v1 - v0), 18);

    // R9: edge mode latch and acknowledge
    wr(3'd0, 8'h05);
    xint0_pin = 1'b0;
    repeat (6) @(negedge clk);
    xint0_pin = 1'b1;
    repeat (6) @(negedge clk);
    check(irq_x0 == 1'b1, "R9 edge latched after pin high", irq_x0, 1);
    rd_exp(3'd0, 8'h0D, "R9 edge flag bit 3");
    pulse_ack(1);
    check(irq_x0 == 1'b0, "R9 ack clears ext0", irq_x0, 0);
    rd_exp(3'd0, 8'h05, "R9 flag cleared");

    // R10: level mode on ext1
    wr(3'd0, 8'h00);
    xint1_pin = 1'b0;
    repeat (5) @(negedge clk);
    check(irq_x1 == 1'b1, "R10 level irq ext1", irq_x1, 1);
    rd_exp(3'd0, 8'h02, "R10 level flag bit 1");
    xint1_pin = 1'b1;
    repeat (5) @(negedge clk);
    check(irq_x1 == 1'b0, "R10 ext1 follows pin", irq_x1, 0);
    rd_exp(3'd0, 8'h00, "R10 flag follows pin");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R2 all reads answered", sb_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule